// File: doc/BRIEF.md
# Clock-control register port with SPI access

This block lets an SPI master, either off-chip or inside the chip, read and write a small set of 8-bit clock-control registers. All SPI pins are sampled by the system clock. Each pin passes through a short synchroniser, and the edges of the serial clock are found in the system-clock domain. As a result, every piece of state, including the register storage, runs in one clock domain.

A transaction opens when chip select falls. The first byte is a command, which selects streaming write or streaming read. The second byte is the start address. Every later byte reads or writes one register, and the address advances by one after each byte. Only a rising chip select ends the burst.

The registers drive four clock-control outputs:
- oscillator free-run mode,
- core clock source,
- PLL output selection,
- PLL feedback divider.

Top module: `clkctl_spi_regs`

## Requirements
- R1: During and after reset the outputs hold their reset values: `dco_mode_o`=0x01 (address 0x08), `clk_src_o`=0x01 (address 0x09), `pll_sel_o`=0x00 (address 0x11), `pll_div_o`=0x04 (address 0x12), and `spi_miso` is 0.
- R2: The interface uses SPI mode 0 with the most significant bit first. MOSI is sampled on rising SCK. Each SCK level must last at least 5 system-clock cycles.
- R3: The first byte after chip select falls is the command. 0x80 opens a streaming write and 0x40 opens a streaming read. With any other code, the rest of the transaction writes nothing and `spi_miso` stays 0.
- R4: The second byte is the start address. Each following data byte uses the next address, in both write and read streaming.
- R5: Only a rising chip select ends a transaction. A partly shifted byte is then discarded, and the next transaction must start with a fresh command byte.
- R6: The four outputs show the stored bytes at addresses 0x08, 0x09, 0x11 and 0x12.
- R7: In a read, each data byte returns the register at the current address on `spi_miso`, most significant bit first. The first bit is present before the byte's first rising SCK. Each later bit appears after a falling SCK.
- R8: Writes to addresses other than the four implemented ones are ignored, but they still advance the address. Reads from those addresses return 0x00.
- R9: A written byte appears on its output within 6 system-clock cycles after the byte's eighth rising SCK. An output changes only as the result of such a write.
- R10: If chip select rises at the same instant as the eighth rising SCK of a data byte, that byte is still written and the transaction ends.
- R11: While chip select is high, `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock (asynchronous) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| dco_mode_o | output | 8 | Oscillator free-run control byte (address 0x08) |
| clk_src_o | output | 8 | Core clock source byte (address 0x09) |
| pll_sel_o | output | 8 | PLL output select byte (address 0x11) |
| pll_div_o | output | 8 | PLL feedback divider byte (address 0x12) |

## Verification
The end of a transaction and the completion of a data byte can land in the same system-clock cycle. This happens when chip select and the eighth rising SCK of the last byte reach the synchronisers together. The bench provokes this by raising both pins at the same instant during a divider write. It then judges the result at the ports in two ways:
- The divider output must show the new byte.
- A following read burst, opened with a fresh command, must return that byte from the divider address.

// File: rtl/clkctl_spi_pkg.sv
package clkctl_spi_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NREG = 4;

  localparam logic [7:0] OP_WRITE = 8'h80;
  localparam logic [7:0] OP_READ  = 8'h40;

  // index 0: free-run, 1: clock source, 2: PLL select, 3: PLL divider
  localparam logic [NREG-1:0][AW-1:0] REG_ADDRS = {8'h12, 8'h11, 8'h09, 8'h08};
  localparam logic [NREG-1:0][DW-1:0] REG_RESET = {8'h04, 8'h00, 8'h01, 8'h01};

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_t;
  typedef enum logic {MODE_WR, MODE_RD} mode_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_busy,
  output logic cs_done,
  output logic mosi_s
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sck_q, cs_q, mosi_q;
  logic              sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck_i};
      cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      sck_d  <= sck_q[LAST];
      cs_d   <= cs_q[LAST];
    end
  end

  // busy uses the delayed select so an edge arriving with the release still counts
  assign cs_busy  = ~cs_d;
  assign cs_done  = cs_q[LAST] & ~cs_d;
  assign sck_rise = cs_busy & sck_q[LAST] & ~sck_d;
  assign sck_fall = cs_busy & ~sck_q[LAST] & sck_d;
  assign mosi_s   = mosi_q[LAST];
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          rise,
  input  logic          fall,
  input  logic          mosi_s,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          miso
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [DW-2:0] rx_q;
  logic [DW-1:0] tx_q;

  assign rx_byte   = {rx_q, mosi_s};
  assign byte_done = rise && (cnt == CNT_LAST);
  assign miso      = tx_q[DW-1];

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      cnt  <= '0;
      rx_q <= '0;
      tx_q <= '0;
    end else begin
      if (rise) begin
        rx_q <= rx_byte[DW-2:0];
        cnt  <= (cnt == CNT_LAST) ? '0 : cnt + CW'(1);
      end
      if (load)
        tx_q <= load_val;
      else if (fall && cnt != '0)
        tx_q <= {tx_q[DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import clkctl_spi_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          cs_done,
  output logic          wr_stb,
  output logic          rd_load,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output phase_t        phase
);
  mode_t         mode;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst || cs_done) begin
      phase <= PH_CMD;
      if (rst) begin
        mode <= MODE_WR;
        ptr  <= '0;
      end
    end else if (byte_done) begin
      unique case (phase)
        PH_CMD: begin
          if (rx_byte == OP_WRITE) begin
            phase <= PH_ADDR;
            mode  <= MODE_WR;
          end else if (rx_byte == OP_READ) begin
            phase <= PH_ADDR;
            mode  <= MODE_RD;
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_ADDR: begin
          ptr   <= rx_byte[AW-1:0];
          phase <= PH_DATA;
        end
        PH_DATA: ptr <= ptr + AW'(1);
        default: phase <= PH_SKIP;
      endcase
    end
  end

  assign wr_stb  = byte_done && phase == PH_DATA && mode == MODE_WR;
  assign rd_load = byte_done && mode == MODE_RD && (phase == PH_ADDR || phase == PH_DATA);
  assign wr_addr = ptr;
  assign rd_addr = (phase == PH_ADDR) ? rx_byte[AW-1:0] : ptr + AW'(1);
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4,
  parameter logic [NREG-1:0][AW-1:0] ADDRS = '0,
  parameter logic [NREG-1:0][DW-1:0] RSTV  = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [DW-1:0]             wdata,
  input  logic [AW-1:0]             raddr,
  output logic [DW-1:0]             rdata,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= RSTV;
    end else if (we) begin
      for (int i = 0; i < NREG; i++)
        if (waddr == ADDRS[i]) regs_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == ADDRS[i]) rdata = regs_q[i];
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/clkctl_spi_regs.sv
module clkctl_spi_regs
  import clkctl_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [DW-1:0] dco_mode_o,
  output logic [DW-1:0] clk_src_o,
  output logic [DW-1:0] pll_sel_o,
  output logic [DW-1:0] pll_div_o
);
  logic          sck_rise, sck_fall, cs_busy, cs_done, mosi_s;
  logic          byte_done, wr_stb, rd_load;
  logic [DW-1:0] rx_byte, rd_data;
  logic [AW-1:0] wr_addr, rd_addr;
  phase_t        phase;
  logic [NREG-1:0][DW-1:0] regs;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_busy(cs_busy),
    .cs_done(cs_done), .mosi_s(mosi_s)
  );

  spi_byte_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .busy(cs_busy), .rise(sck_rise), .fall(sck_fall),
    .mosi_s(mosi_s), .load(rd_load), .load_val(rd_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_cmd_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .byte_done(byte_done), .rx_byte(rx_byte),
    .cs_done(cs_done), .wr_stb(wr_stb), .rd_load(rd_load),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .phase(phase)
  );

  cfg_regbank #(
    .DW(DW), .AW(AW), .NREG(NREG), .ADDRS(REG_ADDRS), .RSTV(REG_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .we(wr_stb), .waddr(wr_addr), .wdata(rx_byte),
    .raddr(rd_addr), .rdata(rd_data), .regs_o(regs)
  );

  assign dco_mode_o = regs[0];
  assign clk_src_o  = regs[1];
  assign pll_sel_o  = regs[2];
  assign pll_div_o  = regs[3];
endmodule

// File: rtl/clkctl_spi_regs_chk.sv
module clkctl_spi_regs_chk
  import clkctl_spi_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          spi_miso,
  input logic [DW-1:0] dco_mode_o,
  input logic [DW-1:0] clk_src_o,
  input logic [DW-1:0] pll_sel_o,
  input logic [DW-1:0] pll_div_o,
  input logic          wr_stb,
  input logic          rd_load,
  input logic          cs_busy,
  input logic          cs_done,
  input phase_t        phase
);
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (dco_mode_o == 8'h01 && clk_src_o == 8'h01 && pll_sel_o == 8'h00 &&
             pll_div_o == 8'h04 && spi_miso == 1'b0));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable({dco_mode_o, clk_src_o, pll_sel_o, pll_div_o}));

  p_excl_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_load}));

  p_fresh_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    cs_done |=> phase == PH_CMD);

  p_idle_miso_r11: assert property (@(posedge clk) disable iff (rst)
    !cs_busy |=> !spi_miso);
endmodule

bind clkctl_spi_regs clkctl_spi_regs_chk u_chk (
  .clk(clk), .rst(rst), .spi_miso(spi_miso), .dco_mode_o(dco_mode_o),
  .clk_src_o(clk_src_o), .pll_sel_o(pll_sel_o), .pll_div_o(pll_div_o),
  .wr_stb(wr_stb), .rd_load(rd_load), .cs_busy(cs_busy), .cs_done(cs_done),
  .phase(phase)
);

// File: tb/sim_clkctl_spi_regs.sv
`timescale 1ns/1ps
module sim_clkctl_spi_regs;
  localparam int HP = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0] dco_mode, clk_src, pll_sel, pll_div;

  int checks = 0, errors = 0;
  bit done = 0, mon_on = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  clkctl_spi_regs u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .dco_mode_o(dco_mode), .clk_src_o(clk_src),
    .pll_sel_o(pll_sel), .pll_div_o(pll_div)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nbits, input bit cs_with_last);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      wait_clk(HP);
      sck = 1'b1;
      if (i == 0 && cs_with_last) cs_n = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] b);
    spi_bits(b, 8, 1'b0);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_end();
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(2 * HP);
  endtask

  task automatic read_burst(input logic [7:0] addr, input int n);
    mon_on = 1;
    cs_begin();
    spi_byte(8'h40);
    spi_byte(addr);
    for (int k = 0; k < n; k++) spi_byte(8'h00);
    cs_end();
    mon_on = 0;
  endtask

  // monitor: rebuilds each byte from miso on rising SCK and scores data bytes
  logic [7:0] mon_sh = '0;
  int mon_bits = 0, mon_bytes = 0;
  always @(negedge cs_n) begin
    mon_bits = 0;
    mon_bytes = 0;
  end
  always @(posedge sck) begin
    if (cs_n === 1'b0) begin
      mon_sh = {mon_sh[6:0], miso};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        mon_bytes++;
        if (mon_on && mon_bytes > 2) begin
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7 unexpected read byte got %02h exp none", mon_sh);
          end else begin
            chk(tag_q.pop_front(), mon_sh, exp_q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run hung got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    // R1: reset values
    chk("R1 dco_mode", dco_mode, 8'h01);
    chk("R1 clk_src", clk_src, 8'h01);
    chk("R1 pll_sel", pll_sel, 8'h00);
    chk("R1 pll_div", pll_div, 8'h04);
    chk("R1 miso", {7'd0, miso}, 8'h00);
    rst = 1'b0;
    wait_clk(4);

    // R4 R6: write burst to 0x08,0x09
    cs_begin(); spi_byte(8'h80); spi_byte(8'h08); spi_byte(8'h00); spi_byte(8'h00); cs_end();
    chk("R6 dco_mode after write", dco_mode, 8'h00);
    chk("R4 clk_src via increment", clk_src, 8'h00);

    // R9 R2: divider visible before chip select rises
    cs_begin(); spi_byte(8'h80); spi_byte(8'h12); spi_byte(8'h03);
    chk("R9 pll_div within byte window", pll_div, 8'h03);
    cs_end();

    cs_begin(); spi_byte(8'h80); spi_byte(8'h11); spi_byte(8'h02); cs_end();
    chk("R6 pll_sel", pll_sel, 8'h02);

    // R7 R8: read 0x08,0x09,0x0A
    push(8'h00, "R7 read 0x08"); push(8'h00, "R7 read 0x09"); push(8'h00, "R8 read 0x0A");
    read_burst(8'h08, 3);

    // R8: write across the unimplemented 0x10
    cs_begin(); spi_byte(8'h80); spi_byte(8'h10); spi_byte(8'h55); spi_byte(8'h66); spi_byte(8'hC7); cs_end();
    chk("R8 pll_sel after skip", pll_sel, 8'h66);
    chk("R8 pll_div after skip", pll_div, 8'hC7);
    chk("R8 dco_mode untouched", dco_mode, 8'h00);
    push(8'h00, "R8 read 0x10"); push(8'h66, "R7 read 0x11"); push(8'hC7, "R7 read 0x12");
    read_burst(8'h10, 3);

    // R3: unknown command 0x20, miso stays 0
    mon_on = 1;
    push(8'h00, "R3 miso under bad command");
    cs_begin(); spi_byte(8'h20); spi_byte(8'h12); spi_byte(8'h09); cs_end();
    mon_on = 0;
    chk("R3 pll_div unchanged", pll_div, 8'hC7);

    // R5: partial byte dropped, next transaction needs a command
    cs_begin(); spi_byte(8'h80); spi_byte(8'h12); spi_bits(8'hFF, 4, 1'b0); cs_end();
    chk("R5 pll_div after partial byte", pll_div, 8'hC7);
    push(8'hC7, "R5 fresh read after partial"); push(8'h00, "R4 read increments to 0x13");
    read_burst(8'h12, 2);

    // R10: chip select rises with the eighth rising SCK
    cs_begin(); spi_byte(8'h80); spi_byte(8'h12); spi_bits(8'h05, 8, 1'b1); wait_clk(2 * HP);
    chk("R10 pll_div coincident release", pll_div, 8'h05);
    push(8'h05, "R10 read back after coincident release");
    read_burst(8'h12, 1);

    // R11: idle miso
    wait_clk(3);
    chk("R11 miso idle", {7'd0, miso}, 8'h00);
    chk("R7 all read bytes scored", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule